// File: doc/BRIEF.md
# Scan-Testable Pipelined Add/Subtract Tree

The block sums sixteen signed 24-bit operands through a binary tree of fifteen adder/subtractor nodes arranged in four levels. An input register stage captures the operands. Every node then writes its result into a pipeline register. Each node has its own one-bit line that picks addition or subtraction, so a caller can form any signed combination of the leaves. The root result leaves the block sign-extended to 28 bits.

For test, any node can be switched on its own into a serial mode. In that mode its result register becomes a shift chain and the node's add/subtract line carries the serial input bit. Nodes further down the tree keep computing normally on whatever pattern has been shifted in. This lets one stage be preloaded with a known value while the stages that consume it are exercised. Each node's register MSB is brought out as a serial output.

Top module: `addsub_scan_tree`

## Requirements
- R1: A node in normal mode with its mode line at 0 stores A+B modulo 2^24 on the next clock, where A comes from the even-numbered child and B from the odd-numbered child.
- R2: A node in normal mode with its mode line at 1 stores A−B modulo 2^24 on the next clock.
- R3: Node numbering and independence: nodes 0–7 combine leaves 2j and 2j+1. Nodes 8–11 combine level-one nodes 2j and 2j+1. Nodes 12–13 combine level-two nodes. Node 14 is the root. Mode bit k and test bit k affect node k only.
- R4: With every node in normal mode, the sum for operands applied before clock edge n appears on the root output after edge n+4, which is five registers in total.
- R5: A node whose test bit is 1 loads its register shifted one place toward the MSB, with its mode line entering bit 0.
- R6: scan_out bit k always equals bit 23 of node k's register.
- R7: A node in normal mode uses the values held in its children's registers, including values that were loaded by shifting.
- R8: A synchronous reset clears the leaf registers and all node registers, so root_out and scan_out read zero after the reset edge.
- R9: root_out equals the root node's 24-bit register sign-extended to 28 bits.
- R10: Node results wrap modulo 2^24 on overflow, and no wider intermediate value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| leaf_in | input | 384 | Sixteen 24-bit operands; leaf j is bits [24j+23:24j] |
| mode_sd | input | 15 | Per node: 1 = subtract, 0 = add; serial input bit while in test mode |
| test_en | input | 15 | Per node: 1 = shift mode |
| scan_out | output | 15 | Per node: MSB of its register |
| root_out | output | 28 | Sign-extended root result |

## Verification
A behavioural model steps alongside the design and is compared on every clock. The stimulus runs through several input patterns. Random operands with every node adding separate correct carry handling from plain bit routing. All-subtract and per-cycle random mode bits show whether each node's own select is honoured and whether operand order is right. Operands at the positive extreme force 24-bit wraparound. Directed sequences do four further things: pin the five-cycle latency with a single pulse of operands, shift known patterns into the root and into a leaf-level node, confirm that the shifted value travels down the tree while its consumers stay in normal mode, and confirm that a reset in the middle of the run clears the pipeline.

// File: rtl/ast_pkg.sv
`timescale 1ns/1ps
package ast_pkg;

    // first flat node index of tree level lv (levels start at 1)
    function automatic int lvl_off(input int nleaf, input int lv);
        return nleaf - (nleaf >> (lv - 1));
    endfunction

    // number of nodes on tree level lv
    function automatic int lvl_cnt(input int nleaf, input int lv);
        return nleaf >> lv;
    endfunction

endpackage

// File: rtl/ast_leaf_stage.sv
`timescale 1ns/1ps
module ast_leaf_stage #(
    parameter int OPW      = 24,
    parameter int NUM_LEAF = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_LEAF*OPW-1:0]          leaf_i,
    output logic [NUM_LEAF-1:0][OPW-1:0]     leaf_q_o
);

    logic [NUM_LEAF-1:0][OPW-1:0] leaf_d, leaf_q;

    always_comb begin
        for (int j = 0; j < NUM_LEAF; j++) begin
            leaf_d[j] = leaf_i[j*OPW +: OPW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            leaf_q <= '0;
        end else begin
            leaf_q <= leaf_d;
        end
    end

    assign leaf_q_o = leaf_q;

    AST_LEAF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> leaf_q == $past(leaf_i)) else $error("leaf capture"); // R4

endmodule

// File: rtl/ast_addsub_node.sv
`timescale 1ns/1ps
module ast_addsub_node #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         mode_sd,
    input  logic         test_en,
    output logic [W-1:0] res_q_o,
    output logic         scan_o
);

    logic [W-1:0] acc_d, acc_q;
    logic [W-1:0] opb_x, prop, gen, sum;
    logic         cin;

    // ripple carry: carry-in equals mode, B inverted when subtracting
    always_comb begin
        opb_x = opb ^ {W{mode_sd}};
        prop  = opa ^ opb_x;
        gen   = opa & opb_x;
        cin   = mode_sd;
        sum   = '0;
        for (int i = 0; i < W; i++) begin
            sum[i] = prop[i] ^ cin;
            cin    = gen[i] | (prop[i] & cin);
        end
        acc_d = test_en ? {acc_q[W-2:0], mode_sd} : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign res_q_o = acc_q;
    assign scan_o  = acc_q[W-1];

    AST_NODE_ADD: assert property (@(posedge clk) disable iff (rst)
        (!test_en && !mode_sd) |=> acc_q == W'($past(opa) + $past(opb))) else $error("add"); // R1
    AST_NODE_SUB: assert property (@(posedge clk) disable iff (rst)
        (!test_en && mode_sd) |=> acc_q == W'($past(opa) - $past(opb))) else $error("sub"); // R2
    AST_NODE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        test_en |=> (acc_q[W-1:1] == $past(acc_q[W-2:0])) && (acc_q[0] == $past(mode_sd))) else $error("shift"); // R5
    AST_NODE_RESET: assert property (@(posedge clk)
        rst |=> acc_q == '0) else $error("reset"); // R8

endmodule

// File: rtl/addsub_scan_tree.sv
`timescale 1ns/1ps
module addsub_scan_tree
    import ast_pkg::*;
#(
    parameter int OPW      = 24,
    parameter int NUM_LEAF = 16,
    parameter int OUT_W    = 28
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_LEAF*OPW-1:0]   leaf_in,
    input  logic [NUM_LEAF-2:0]       mode_sd,
    input  logic [NUM_LEAF-2:0]       test_en,
    output logic [NUM_LEAF-2:0]       scan_out,
    output logic [OUT_W-1:0]          root_out
);

    localparam int LEVELS   = $clog2(NUM_LEAF);
    localparam int NUM_NODE = NUM_LEAF - 1;
    localparam int EXT_W    = OUT_W - OPW;

    logic [NUM_LEAF-1:0][OPW-1:0] leaf_q;
    logic [NUM_NODE-1:0][OPW-1:0] node_q;

    ast_leaf_stage #(
        .OPW      (OPW),
        .NUM_LEAF (NUM_LEAF)
    ) u_leaf (
        .clk      (clk),
        .rst      (rst),
        .leaf_i   (leaf_in),
        .leaf_q_o (leaf_q)
    );

    for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_lvl
        for (genvar j = 0; j < lvl_cnt(NUM_LEAF, lv); j++) begin : g_node
            localparam int K = lvl_off(NUM_LEAF, lv) + j;
            logic [OPW-1:0] a_w, b_w;
            if (lv == 1) begin : g_from_leaf
                assign a_w = leaf_q[2*j];
                assign b_w = leaf_q[2*j+1];
            end else begin : g_from_node
                assign a_w = node_q[lvl_off(NUM_LEAF, lv-1) + 2*j];
                assign b_w = node_q[lvl_off(NUM_LEAF, lv-1) + 2*j + 1];
            end
            ast_addsub_node #(
                .W (OPW)
            ) u_node (
                .clk     (clk),
                .rst     (rst),
                .opa     (a_w),
                .opb     (b_w),
                .mode_sd (mode_sd[K]),
                .test_en (test_en[K]),
                .res_q_o (node_q[K]),
                .scan_o  (scan_out[K])
            );
        end
    end

    assign root_out = {{EXT_W{node_q[NUM_NODE-1][OPW-1]}}, node_q[NUM_NODE-1]};

endmodule

// File: tb/addsub_scan_tree_bench.sv
`timescale 1ns/1ps
module addsub_scan_tree_bench;

    localparam int W  = 24;
    localparam int NL = 16;
    localparam int NN = 15;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NL*W-1:0] leaf_in = '0;
    logic [NN-1:0]   mode_sd = '0;
    logic [NN-1:0]   test_en = '0;
    logic [NN-1:0]   scan_out;
    logic [27:0]     root_out;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 0;

    logic [W-1:0] m_leaf [NL];
    logic [W-1:0] m_node [NN];

    always #2 clk = ~clk;

    addsub_scan_tree u_addsub_scan_tree (
        .clk      (clk),
        .rst      (rst),
        .leaf_in  (leaf_in),
        .mode_sd  (mode_sd),
        .test_en  (test_en),
        .scan_out (scan_out),
        .root_out (root_out)
    );

    // behavioural reference, one update per clock
    always @(posedge clk) begin
        logic [W-1:0] a, b;
        int off, prev, cnt, k;
        if (rst) begin
            for (int j = 0; j < NL; j++) m_leaf[j] <= '0;
            for (int j = 0; j < NN; j++) m_node[j] <= '0;
        end else begin
            for (int j = 0; j < NL; j++) m_leaf[j] <= leaf_in[j*W +: W];
            off = 0; prev = 0;
            for (int lv = 1; lv <= 4; lv++) begin
                cnt = NL >> lv;
                for (int j = 0; j < cnt; j++) begin
                    k = off + j;
                    a = (lv == 1) ? m_leaf[2*j]   : m_node[prev + 2*j];
                    b = (lv == 1) ? m_leaf[2*j+1] : m_node[prev + 2*j + 1];
                    if (test_en[k]) m_node[k] <= {m_node[k][W-2:0], mode_sd[k]};
                    else if (mode_sd[k]) m_node[k] <= a - b;
                    else m_node[k] <= a + b;
                end
                prev = off;
                off  = off + cnt;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string req);
        logic [NN-1:0] sexp;
        logic [27:0]   rexp;
        for (int k = 0; k < NN; k++) sexp[k] = m_node[k][W-1];
        rexp = {{4{m_node[14][W-1]}}, m_node[14]};
        chk(root_out == rexp, {req, " root (R9)"}, 32'(root_out), 32'(rexp));
        chk(scan_out == sexp, {req, " scan_out (R6)"}, 32'(scan_out), 32'(sexp));
    endtask

    task automatic cyc(input string req);
        @(posedge clk);
        @(negedge clk);
        compare_all(req);
    endtask

    task automatic fill_rand();
        for (int j = 0; j < NL; j++) leaf_in[j*W +: W] = W'($urandom);
    endtask

    task automatic fill_const(input logic [W-1:0] v);
        for (int j = 0; j < NL; j++) leaf_in[j*W +: W] = v;
    endtask

    initial begin
        logic [W-1:0] pat;
        void'($urandom(7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(root_out == '0, "R8 reset root", 32'(root_out), 0);
        chk(scan_out == '0, "R8 reset scan", 32'(scan_out), 0);
        rst = 1'b0;

        // R1: all add, random operands
        mode_sd = '0;
        for (int p = 0; p < 20; p++) begin fill_rand(); cyc("R1"); end
        repeat (6) cyc("R1");

        // R10: positive extreme wraps
        fill_const(24'h7FFFFF);
        repeat (6) cyc("R10");
        chk(root_out == 28'hFFFFFF0, "R10 wrap", 32'(root_out), 32'h0FFFFFF0);

        // R2: all subtract
        mode_sd = '1;
        for (int p = 0; p < 20; p++) begin fill_rand(); cyc("R2"); end
        fill_const(24'h800000);
        repeat (6) cyc("R2");

        // R3: per-node mode bits random every cycle
        for (int p = 0; p < 30; p++) begin
            fill_rand();
            mode_sd = NN'($urandom);
            cyc("R3");
        end

        // R4: single pulse of ones, all add
        mode_sd = '0;
        fill_const('0);
        repeat (6) cyc("R4");
        fill_const(24'd1);
        cyc("R4");
        fill_const('0);
        repeat (3) cyc("R4");
        chk(root_out == 28'd0, "R4 before latency", 32'(root_out), 0);
        cyc("R4");
        chk(root_out == 28'd16, "R4 at latency", 32'(root_out), 16);
        cyc("R4");
        chk(root_out == 28'd0, "R4 after pulse", 32'(root_out), 0);

        // R5/R6: shift a pattern into the root node
        pat = 24'h5A3C96;
        test_en = '0;
        test_en[14] = 1'b1;
        for (int i = W-1; i >= 0; i--) begin
            mode_sd[14] = pat[i];
            cyc("R5");
        end
        chk(root_out == 28'h05A3C96, "R5 root loaded", 32'(root_out), 32'h05A3C96);
        for (int i = 0; i < W; i++) begin
            chk(scan_out[14] == pat[W-1-i], "R6 serial out", 32'(scan_out[14]), 32'(pat[W-1-i]));
            mode_sd[14] = 1'b0;
            cyc("R6");
        end
        test_en = '0;
        mode_sd = '0;
        repeat (6) cyc("R5");

        // R7/R9: shift into node 0 while its consumers run normally
        pat = 24'hABCDE5;
        test_en[0] = 1'b1;
        mode_sd[3] = 1'b1;
        for (int i = W-1; i >= 0; i--) begin
            mode_sd[0] = pat[i];
            cyc("R7");
        end
        test_en[0] = 1'b0;
        mode_sd[0] = 1'b0;
        repeat (3) cyc("R7");
        chk(root_out == 28'hFABCDE5, "R7 R9 scanned value at root", 32'(root_out), 32'h0FABCDE5);

        // R8: reset in mid-run
        mode_sd = NN'($urandom);
        for (int p = 0; p < 8; p++) begin fill_rand(); cyc("R3"); end
        rst = 1'b1;
        cyc("R8");
        chk(root_out == '0, "R8 mid reset root", 32'(root_out), 0);
        chk(scan_out == '0, "R8 mid reset scan", 32'(scan_out), 0);
        rst = 1'b0;
        fill_const('0);
        repeat (2) cyc("R8");
        chk(root_out == '0, "R8 pipeline cleared", 32'(root_out), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R4 act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule